// File: doc/BRIEF.md
# Bus Listener Handshake Engine

This block is the receiving half of the three-wire byte handshake used on a parallel instrument bus. On a read request it takes one byte from the active-low data lines and paces the talker with two open-collector outputs: "not ready" and "not accepted". Each output is modelled as a pull-low enable, where 1 means the line is driven low. The received byte leaves the block as a 16-bit word. The data sits in the low byte and the state of the bus control lines, plus two error flags, sits in the high byte.

A one-entry pushback register lets the consumer hand a word back. The next read request then returns that word without touching the bus. While the engine is idle and the attention line asserts, it pulls both handshake lines low at once, with no clock involved. An interface-clear on the bus aborts any cycle in progress, releases the lines and empties the pushback register.

Top module: `lsn_handshake`

## Requirements
- R1: After reset, both pull enables are 0, `word_valid` is 0 and `push_err` is 0.
- R2: While the engine is idle, `atn_n` low drives both `nrfd_pull` and `ndac_pull` to 1 combinationally, with no clock edge needed.
- R3: A read request holds both lines low. Once the data-valid line is seen high, the engine releases not-ready (`nrfd_pull`=0) and keeps `ndac_pull`=1.
- R4: When data-valid goes low, `nrfd_pull` returns to 1 and the byte is captured inverted. Only after that is `ndac_pull` released. When data-valid returns high, `ndac_pull` goes to 1 again, `word_out` is presented with a one-cycle `word_valid`, and both lines stay pulled until the next cycle.
- R5: If attention is asserted when the byte is captured, bit 7 of the word is forced to 0. Otherwise all 8 data bits are kept.
- R6: Status bits are set to 1 when the line is low at capture: bit 8 attention, bit 9 end-or-identify, bit 10 service-request, bit 11 remote-enable. Bit 12 is the interface-clear error, bit 13 is the timeout error, and bits 15:14 are 0.
- R7: Waiting for data-valid high, either before ready or after acceptance, for more than `TIMEOUT_TICKS` cycles ends the cycle. The word then carries bit 13 together with any captured data, and both lines stay pulled. Waiting for data-valid low never times out.
- R8: Interface-clear low aborts at any time. It releases both lines, empties the pushback register and, if a cycle was running, delivers a word with bit 12 set.
- R9: A pushed word is returned by the next read request one cycle later, with the handshake lines unchanged. The register is empty afterwards.
- R10: A push while a word is held raises `push_err` for one cycle and keeps the held word.
- R11: A read request during a cycle in progress is ignored; exactly one word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dio_n | input | 8 | Data lines, active low |
| dav_n | input | 1 | Data-valid line, active low |
| atn_n | input | 1 | Attention line, active low |
| eoi_n | input | 1 | End-or-identify line, active low |
| srq_n | input | 1 | Service-request line, active low |
| ren_n | input | 1 | Remote-enable line, active low |
| ifc_n | input | 1 | Interface-clear line, active low |
| rd_req | input | 1 | Request to receive one word |
| push_valid | input | 1 | Push `push_word` back into the pushback register |
| push_word | input | 16 | Word to push back |
| nrfd_pull | output | 1 | 1 pulls the not-ready line low |
| ndac_pull | output | 1 | 1 pulls the not-accepted line low |
| word_valid | output | 1 | One-cycle strobe for `word_out` |
| word_out | output | 16 | Received word: data low byte, flags high byte |
| push_err | output | 1 | One-cycle strobe: push rejected |

## Verification
The hardest state to reach from the ports is a talker that stalls after the byte has been accepted. The engine has released not-accepted and sits waiting for data-valid to return high. The bench plays the talker itself: it walks the handshake step by step, watching the pull outputs, and then holds data-valid low at that point so the second timeout window runs out while the captured byte is still in place. Interface-clear is injected in the same way, in the middle of a cycle with a word already pushed back. This shows that the abort both releases the lines and discards the pushback.

// File: rtl/lsn_pkg.sv
`timescale 1ns/1ps
package lsn_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int FLG_ATN = 8;
    localparam int FLG_EOI = 9;
    localparam int FLG_SRQ = 10;
    localparam int FLG_REN = 11;
    localparam int FLG_IFC = 12;
    localparam int FLG_TMO = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REL,
        ST_READY,
        ST_CAPTURE,
        ST_ACCEPT,
        ST_FINISH,
        ST_ERROR
    } lsn_state_e;

    // control lines after synchronisation, 1 = asserted on the bus
    typedef struct packed {
        logic atn;
        logic eoi;
        logic srq;
        logic ren;
        logic ifc;
    } lsn_ctl_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [BYTE_W-1:0] dio_n,
                                                    input lsn_ctl_t c);
        logic [BYTE_W-1:0] d;
        d = ~dio_n;
        if (c.atn) d[BYTE_W-1] = 1'b0;
        return {2'b00, 1'b0, c.ifc, c.ren, c.srq, c.eoi, c.atn, d};
    endfunction

endpackage

// File: rtl/lsn_sync.sv
`timescale 1ns/1ps
module lsn_sync #(
    parameter int          W       = 14,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lsn_timer.sv
`timescale 1ns/1ps
module lsn_timer #(
    parameter int TICKS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TICKS + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= CW'(TICKS);
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = run && (cnt == '0);
endmodule

// File: rtl/lsn_pushback.sv
`timescale 1ns/1ps
module lsn_pushback
    import lsn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              take,
    output logic              held,
    output logic [WORD_W-1:0] held_word,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_word <= '0;
            err       <= 1'b0;
        end else begin
            err <= 1'b0;
            if (flush) begin
                held <= 1'b0;
            end else if (push) begin
                if (held) begin
                    err <= 1'b1;
                end else begin
                    held      <= 1'b1;
                    held_word <= push_data;
                end
            end else if (take) begin
                held <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lsn_fsm.sv
`timescale 1ns/1ps
module lsn_fsm
    import lsn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] s_dio_n,
    input  logic              s_dav_n,
    input  lsn_ctl_t          s_ctl,
    input  logic              atn_now,
    input  logic              rd_req,
    input  logic              pb_held,
    input  logic [WORD_W-1:0] pb_word,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic              tmr_run,
    output logic              pb_take,
    output lsn_state_e        st,
    output logic              nrfd_pull,
    output logic              ndac_pull,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_out
);
    logic              hold_busy;
    logic [WORD_W-1:0] cap_q;
    logic              start_bus;

    assign start_bus = (st == ST_IDLE) && rd_req && !pb_held && !s_ctl.ifc;
    assign pb_take   = (st == ST_IDLE) && rd_req &&  pb_held && !s_ctl.ifc;
    assign tmr_load  = start_bus || (st == ST_CAPTURE);
    assign tmr_run   = (st == ST_WAIT_REL) || (st == ST_ACCEPT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            hold_busy  <= 1'b0;
            cap_q      <= '0;
            word_valid <= 1'b0;
            word_out   <= '0;
        end else begin
            word_valid <= 1'b0;
            if (s_ctl.ifc) begin
                if (st != ST_IDLE) begin
                    word_out   <= cap_q | (WORD_W'(1) << FLG_IFC);
                    word_valid <= 1'b1;
                end
                st        <= ST_IDLE;
                hold_busy <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (pb_take) begin
                            word_out   <= pb_word;
                            word_valid <= 1'b1;
                        end else if (start_bus) begin
                            cap_q <= '0;
                            st    <= ST_WAIT_REL;
                        end
                    end
                    ST_WAIT_REL: begin
                        if (s_dav_n)          st <= ST_READY;
                        else if (tmr_expired) st <= ST_ERROR;
                    end
                    ST_READY: begin
                        if (!s_dav_n) st <= ST_CAPTURE;
                    end
                    ST_CAPTURE: begin
                        cap_q <= pack_word(s_dio_n, s_ctl);
                        st    <= ST_ACCEPT;
                    end
                    ST_ACCEPT: begin
                        if (s_dav_n)          st <= ST_FINISH;
                        else if (tmr_expired) st <= ST_ERROR;
                    end
                    ST_FINISH: begin
                        word_out   <= cap_q;
                        word_valid <= 1'b1;
                        hold_busy  <= 1'b1;
                        st         <= ST_IDLE;
                    end
                    ST_ERROR: begin
                        word_out   <= cap_q | (WORD_W'(1) << FLG_TMO);
                        word_valid <= 1'b1;
                        hold_busy  <= 1'b1;
                        st         <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        if (st == ST_IDLE) begin
            nrfd_pull = hold_busy | atn_now;
            ndac_pull = hold_busy | atn_now;
        end else begin
            nrfd_pull = (st != ST_READY);
            ndac_pull = (st != ST_ACCEPT);
        end
    end
endmodule

// File: rtl/lsn_handshake.sv
`timescale 1ns/1ps
module lsn_handshake
    import lsn_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_TICKS = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  dio_n,
    input  logic        dav_n,
    input  logic        atn_n,
    input  logic        eoi_n,
    input  logic        srq_n,
    input  logic        ren_n,
    input  logic        ifc_n,
    input  logic        rd_req,
    input  logic        push_valid,
    input  logic [15:0] push_word,
    output logic        nrfd_pull,
    output logic        ndac_pull,
    output logic        word_valid,
    output logic [15:0] word_out,
    output logic        push_err
);
    localparam int SV_W = BYTE_W + 6;

    logic [SV_W-1:0]   s_vec;
    logic [BYTE_W-1:0] s_dio_n;
    logic              s_dav_n;
    logic              s_ifc;
    lsn_ctl_t          s_ctl;
    lsn_state_e        st;
    logic              tmr_load, tmr_run, tmr_expired;
    logic              pb_take, pb_held;
    logic [WORD_W-1:0] pb_word;

    lsn_sync #(.W(SV_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dio_n, dav_n, atn_n, eoi_n, srq_n, ren_n, ifc_n}),
        .q   (s_vec)
    );

    assign s_dio_n   = s_vec[SV_W-1 -: BYTE_W];
    assign s_dav_n   = s_vec[5];
    assign s_ctl.atn = ~s_vec[4];
    assign s_ctl.eoi = ~s_vec[3];
    assign s_ctl.srq = ~s_vec[2];
    assign s_ctl.ren = ~s_vec[1];
    assign s_ctl.ifc = ~s_vec[0];
    assign s_ifc     = s_ctl.ifc;

    lsn_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    lsn_pushback u_pushback (
        .clk       (clk),
        .rst       (rst),
        .flush     (s_ifc),
        .push      (push_valid),
        .push_data (push_word),
        .take      (pb_take),
        .held      (pb_held),
        .held_word (pb_word),
        .err       (push_err)
    );

    lsn_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .s_dio_n     (s_dio_n),
        .s_dav_n     (s_dav_n),
        .s_ctl       (s_ctl),
        .atn_now     (~atn_n),
        .rd_req      (rd_req),
        .pb_held     (pb_held),
        .pb_word     (pb_word),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_run     (tmr_run),
        .pb_take     (pb_take),
        .st          (st),
        .nrfd_pull   (nrfd_pull),
        .ndac_pull   (ndac_pull),
        .word_valid  (word_valid),
        .word_out    (word_out)
    );
endmodule

// File: rtl/lsn_handshake_chk.sv
`timescale 1ns/1ps
module lsn_handshake_chk
    import lsn_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        atn_n,
    input logic        nrfd_pull,
    input logic        ndac_pull,
    input logic        word_valid,
    input logic [15:0] word_out,
    input logic        push_valid,
    input logic        push_err,
    input lsn_state_e  st,
    input logic        s_dav_n,
    input logic        s_ifc
);
    assert_reset_released_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && atn_n) |-> (!nrfd_pull && !ndac_pull && !word_valid));

    assert_atn_idle_pull_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !atn_n) |-> (nrfd_pull && ndac_pull));

    assert_ready_after_dav_high_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READY && $past(st) == ST_WAIT_REL) |-> $past(s_dav_n));

    assert_ndac_only_with_nrfd_R4: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !ndac_pull) |-> nrfd_pull);

    assert_word_known_R4: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !$isunknown(word_out));

    assert_done_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (($past(st) == ST_FINISH || $past(st) == ST_ERROR) && !$past(s_ifc))
        |-> (nrfd_pull && ndac_pull && word_valid));

    assert_cmd_mask_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_FINISH && word_valid && word_out[FLG_ATN]) |-> !word_out[7]);

    assert_top_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_FINISH && word_valid) |-> (word_out[15:13] == 3'b000));

    assert_timeout_flag_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ERROR && !$past(s_ifc)) |-> word_out[FLG_TMO]);

    assert_ifc_release_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(s_ifc) && atn_n) |-> (!nrfd_pull && !ndac_pull && st == ST_IDLE));

    assert_push_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        push_err |-> $past(push_valid));
endmodule

bind lsn_handshake lsn_handshake_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .atn_n      (atn_n),
    .nrfd_pull  (nrfd_pull),
    .ndac_pull  (ndac_pull),
    .word_valid (word_valid),
    .word_out   (word_out),
    .push_valid (push_valid),
    .push_err   (push_err),
    .st         (st),
    .s_dav_n    (s_dav_n),
    .s_ifc      (s_ifc)
);

// File: tb/lsn_handshake_tb.sv
`timescale 1ns/1ps
module lsn_handshake_tb;
    localparam int TO = 64;
    localparam int NV = 6;
    // {true data, atn_n, eoi_n, srq_n, ren_n, expected word}
    localparam logic [27:0] VEC [NV] = '{
        {8'hA5, 4'b1111, 16'h00A5},
        {8'hC3, 4'b0111, 16'h0143},
        {8'hFF, 4'b1011, 16'h02FF},
        {8'h80, 4'b0100, 16'h0D00},
        {8'h00, 4'b0000, 16'h0F00},
        {8'h7E, 4'b1001, 16'h067E}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] dio_n = 8'hFF;
    logic dav_n = 1'b1, atn_n = 1'b1, eoi_n = 1'b1, srq_n = 1'b1, ren_n = 1'b1, ifc_n = 1'b1;
    logic rd_req = 1'b0, push_valid = 1'b0;
    logic [15:0] push_word = '0;
    logic nrfd_pull, ndac_pull, word_valid, push_err;
    logic [15:0] word_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lsn_handshake #(.SYNC_STAGES(2), .TIMEOUT_TICKS(TO)) u_dut (
        .clk(clk), .rst(rst), .dio_n(dio_n), .dav_n(dav_n), .atn_n(atn_n),
        .eoi_n(eoi_n), .srq_n(srq_n), .ren_n(ren_n), .ifc_n(ifc_n),
        .rd_req(rd_req), .push_valid(push_valid), .push_word(push_word),
        .nrfd_pull(nrfd_pull), .ndac_pull(ndac_pull), .word_valid(word_valid),
        .word_out(word_out), .push_err(push_err)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // which: 0 nrfd_pull, 1 ndac_pull, 2 word_valid
    task automatic wait_sig(input int which, input logic v, input int lim, output logic hit);
        logic cur;
        hit = 1'b0;
        for (int i = 0; i < lim; i++) begin
            cur = (which == 0) ? nrfd_pull : (which == 1) ? ndac_pull : word_valid;
            if (cur == v) begin
                hit = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_rd();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_xfer(input logic [7:0] data, input logic [3:0] ctl_n, output logic [15:0] w);
        logic hit;
        {atn_n, eoi_n, srq_n, ren_n} = ctl_n;
        dav_n = 1'b1;
        dio_n = 8'hFF;
        repeat (3) @(negedge clk);
        pulse_rd();
        wait_sig(0, 1'b1, 20, hit);
        wait_sig(0, 1'b0, 20, hit);
        chk(hit, "R3 not-ready released after data-valid high", {15'd0, nrfd_pull}, 16'd0);
        chk(ndac_pull == 1'b1, "R3 not-accepted held while ready", {15'd0, ndac_pull}, 16'd1);
        dio_n = ~data;
        dav_n = 1'b0;
        wait_sig(1, 1'b0, 20, hit);
        chk(hit && nrfd_pull, "R4 not-accepted released with not-ready pulled", {14'd0, hit, nrfd_pull}, 16'd3);
        dav_n = 1'b1;
        wait_sig(2, 1'b1, 20, hit);
        chk(hit, "R4 word delivered", {15'd0, hit}, 16'd1);
        w = word_out;
        chk(nrfd_pull && ndac_pull, "R4 both lines pulled at end", {14'd0, nrfd_pull, ndac_pull}, 16'd3);
        dio_n = 8'hFF;
        {atn_n, eoi_n, srq_n, ren_n} = 4'b1111;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'd1, 16'd0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic hit;
        int n;
        int extra;
        bit bad;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!nrfd_pull && !ndac_pull, "R1 lines released after reset", {14'd0, nrfd_pull, ndac_pull}, 16'd0);
        chk(!word_valid && !push_err, "R1 strobes low after reset", {14'd0, word_valid, push_err}, 16'd0);

        // R2 attention while idle, no clock needed
        atn_n = 1'b0;
        #1;
        chk(nrfd_pull && ndac_pull, "R2 attention pulls both lines", {14'd0, nrfd_pull, ndac_pull}, 16'd3);
        atn_n = 1'b1;
        #1;
        chk(!nrfd_pull && !ndac_pull, "R2 lines released with attention gone", {14'd0, nrfd_pull, ndac_pull}, 16'd0);
        repeat (4) @(negedge clk);

        // R5 R6 table of transfers
        for (int k = 0; k < NV; k++) begin
            do_xfer(VEC[k][27:20], VEC[k][19:16], w);
            chk(w == VEC[k][15:0], "R5 R6 captured word", w, VEC[k][15:0]);
        end
        repeat (5) @(negedge clk);
        chk(nrfd_pull && ndac_pull, "R4 lines stay pulled while idle after a cycle", {14'd0, nrfd_pull, ndac_pull}, 16'd3);

        // R7 timeout before ready: data-valid stuck low
        dav_n = 1'b0;
        repeat (4) @(negedge clk);
        pulse_rd();
        n = 1;
        hit = 1'b0;
        for (int i = 0; i < 4 * TO && !hit; i++) begin
            if (word_valid) hit = 1'b1;
            else begin
                @(negedge clk);
                n++;
            end
        end
        chk(hit && word_out[13], "R7 timeout flag before ready", word_out, 16'h2000);
        chk(n >= TO && n <= TO + 8, "R7 timeout latency", 16'(n), 16'(TO));
        chk(nrfd_pull && ndac_pull, "R7 lines pulled after timeout", {14'd0, nrfd_pull, ndac_pull}, 16'd3);
        dav_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7 timeout after acceptance: data-valid never returns high
        pulse_rd();
        wait_sig(0, 1'b1, 20, hit);
        wait_sig(0, 1'b0, 20, hit);
        dio_n = ~8'h5A;
        dav_n = 1'b0;
        wait_sig(1, 1'b0, 20, hit);
        wait_sig(2, 1'b1, 4 * TO, hit);
        chk(hit && word_out == 16'h205A, "R7 timeout after acceptance keeps data", word_out, 16'h205A);
        dav_n = 1'b1;
        dio_n = 8'hFF;
        repeat (4) @(negedge clk);

        // R7 no timeout waiting for data-valid low; R11 request ignored mid-cycle
        pulse_rd();
        wait_sig(0, 1'b1, 20, hit);
        wait_sig(0, 1'b0, 20, hit);
        bad = 1'b0;
        for (int i = 0; i < 3 * TO; i++) begin
            if (word_valid || nrfd_pull) bad = 1'b1;
            if (i == 5) rd_req = 1'b1;
            if (i == 6) rd_req = 1'b0;
            @(negedge clk);
        end
        chk(!bad, "R7 no timeout while waiting for data-valid low", {15'd0, bad}, 16'd0);
        dio_n = ~8'h3C;
        dav_n = 1'b0;
        wait_sig(1, 1'b0, 20, hit);
        dav_n = 1'b1;
        wait_sig(2, 1'b1, 20, hit);
        chk(hit && word_out == 16'h003C, "R11 single word after stray request", word_out, 16'h003C);
        dio_n = 8'hFF;
        @(negedge clk);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            if (word_valid || !nrfd_pull) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R11 no second cycle started", 16'(extra), 16'd0);

        // R9 pushback returned without touching the lines
        push_word = 16'hBEEF;
        push_valid = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
        pulse_rd();
        chk(word_valid && word_out == 16'hBEEF, "R9 pushed word returned", word_out, 16'hBEEF);
        chk(nrfd_pull && ndac_pull, "R9 lines unchanged by pushback read", {14'd0, nrfd_pull, ndac_pull}, 16'd3);
        do_xfer(8'h11, 4'b1111, w);
        chk(w == 16'h0011, "R9 register empty after return", w, 16'h0011);

        // R10 second push rejected
        push_word = 16'h1111;
        push_valid = 1'b1;
        @(negedge clk);
        push_word = 16'h2222;
        @(negedge clk);
        push_valid = 1'b0;
        chk(push_err == 1'b1, "R10 second push flagged", {15'd0, push_err}, 16'd1);
        @(negedge clk);
        chk(push_err == 1'b0, "R10 error strobe one cycle", {15'd0, push_err}, 16'd0);
        pulse_rd();
        chk(word_valid && word_out == 16'h1111, "R10 held word kept", word_out, 16'h1111);

        // R8 interface-clear mid-cycle with a pushed word held
        @(negedge clk);
        pulse_rd();
        wait_sig(0, 1'b1, 20, hit);
        wait_sig(0, 1'b0, 20, hit);
        push_word = 16'h7777;
        push_valid = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
        ifc_n = 1'b0;
        wait_sig(2, 1'b1, 20, hit);
        chk(hit && word_out[12], "R8 clear flag in aborted word", word_out, 16'h1000);
        chk(!nrfd_pull && !ndac_pull, "R8 lines released on clear", {14'd0, nrfd_pull, ndac_pull}, 16'd0);
        repeat (3) @(negedge clk);
        ifc_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!nrfd_pull && !ndac_pull, "R8 lines stay released after clear", {14'd0, nrfd_pull, ndac_pull}, 16'd0);
        do_xfer(8'h96, 4'b1111, w);
        chk(w == 16'h0096, "R8 pushback emptied by clear", w, 16'h0096);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule